// File: doc/BRIEF.md
# Thirty-Two-Fold CIC Interpolator

This block is the final rate-raising stage of an audio upsampling chain. It takes signed samples that arrive at four times the audio frame rate, each marked by a one-cycle strobe, and delivers a new signed sample on every master-clock cycle, which runs at 128 times the frame rate. The output is intended to feed a one-bit noise-shaping modulator directly. Passband droop is corrected by an earlier stage, so this block applies no compensation.

The structure is four comb stages with unit differential delay, then a zero-order hold, then four integrators. The comb stages advance only on the input strobe. The hold keeps the comb result for the 32 master cycles of each input period. The integrators advance on every master cycle. The integrators are 20 bits wider than the input and wrap in two's complement. The overall DC gain of 2^20 is scaled by discarding a parameterised number of low-order bits at the output.

Top module: `cic_interp32`

## Requirements
- R1: While the reset is asserted, and afterwards until the first strobed sample has been captured, `out_data` is zero.
- R2: `out_vld` is low after reset. It rises on the clock edge that samples `in_vld` high for the first time, and it then stays high on every cycle until the next reset.
- R3: `in_data` has no effect on any later output when `in_vld` is low on that edge.
- R4: Number the clock edges from 0, where edge 0 is the one that captures the first strobe, and strobes recur every 32 cycles. The full-precision value present after edge k is y(k) = sum over m of x[m]·g[k−4−32m]. Here x[m] is the m-th strobed sample and g is the five-fold convolution of a 32-tap all-ones window, which has 156 taps with g[0]=1 and g[1]=5. The first input therefore reaches the output four edges after its capture.
- R5: A constant input x held long enough that every tap sees it settles to an output of x·2^(20−TRUNC).
- R6: `out_data` equals floor(y/2^TRUNC) and is IW+20−TRUNC bits wide, signed.
- R7: Full-scale inputs of either sign, in any pattern, give the exact value of R6 with no wraparound at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 128 times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_data | input | IW | Signed input sample |
| in_vld | input | 1 | One-cycle strobe marking a new input sample |
| out_data | output | IW+20−TRUNC | Signed output sample, new every cycle |
| out_vld | output | 1 | High once the first sample has been captured |

## Verification
The strobe is captured by the hold register on edge 0, so `out_vld` is due one edge after the strobe is driven. The integrator pipeline adds four more edges before the first nonzero output, so the value of sample m first appears after edge 32m+4. The bench counts edges from the first strobe and samples every output on the falling edge, which is half a period after the register update it checks. It compares each sample with a convolution against the 156-tap kernel built in the bench. Random values are driven on `in_data` between strobes, so every cycle-accurate match also checks that those values are ignored.

// File: rtl/cic_interp_pkg.sv
package cic_interp_pkg;
  // Bit growth of an N-stage integrator chain driven by a hold of length 2^rl.
  function automatic int cic_growth(input int nstg, input int rl);
    return nstg * rl;
  endfunction
endpackage

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int NSTG = 4,
  parameter int CW   = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [CW-1:0] din,
  output logic signed [CW-1:0] dout
);
  logic signed [CW-1:0] stg   [0:NSTG];
  logic signed [CW-1:0] dly_q [0:NSTG-1];
  logic signed [CW-1:0] dly_d [0:NSTG-1];

  assign stg[0] = din;

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    assign stg[k+1] = stg[k] - dly_q[k];

    always_comb begin
      dly_d[k] = dly_q[k];
      if (en) dly_d[k] = stg[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q[k] <= '0;
      else        dly_q[k] <= dly_d[k];
    end
  end

  assign dout = stg[NSTG];
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int NSTG = 4,
  parameter int W    = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] acc_q [0:NSTG-1];
  logic signed [W-1:0] acc_d [0:NSTG-1];
  logic signed [W-1:0] src   [0:NSTG-1];

  for (genvar k = 0; k < NSTG; k++) begin : g_acc
    if (k == 0) begin : g_first
      assign src[k] = din;
    end else begin : g_next
      assign src[k] = acc_q[k-1];
    end

    always_comb begin
      acc_d[k] = acc_q[k];
      if (en) acc_d[k] = acc_q[k] + src[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q[k] <= '0;
      else        acc_q[k] <= acc_d[k];
    end
  end

  assign dout = acc_q[NSTG-1];
endmodule

// File: rtl/cic_interp32.sv
module cic_interp32
  import cic_interp_pkg::*;
#(
  parameter int IW    = 16,
  parameter int NSTG  = 4,
  parameter int RLOG2 = 5,
  parameter int TRUNC = 20
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [IW-1:0]                       in_data,
  input  logic                                in_vld,
  output logic [IW+NSTG*RLOG2-TRUNC-1:0]      out_data,
  output logic                                out_vld
);
  localparam int GROWTH = cic_growth(NSTG, RLOG2);
  localparam int W      = IW + GROWTH;
  localparam int CW     = IW + NSTG;

  logic signed [CW-1:0] comb_in;
  logic signed [CW-1:0] comb_out;
  logic signed [CW-1:0] comb_hold, hold_d;
  logic                 started_q, started_d;
  logic signed [W-1:0]  integ_in;
  logic signed [W-1:0]  integ_out;

  assign comb_in = {{NSTG{in_data[IW-1]}}, in_data};

  cic_comb_chain #(.NSTG(NSTG), .CW(CW)) u_comb (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_vld),
    .din  (comb_in),
    .dout (comb_out)
  );

  // Zero-order hold of the comb result across one input period.
  always_comb begin
    hold_d    = comb_hold;
    started_d = started_q;
    if (in_vld) begin
      hold_d    = comb_out;
      started_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comb_hold <= '0;
      started_q <= 1'b0;
    end else begin
      comb_hold <= hold_d;
      started_q <= started_d;
    end
  end

  assign integ_in = {{(W-CW){comb_hold[CW-1]}}, comb_hold};

  cic_integ_chain #(.NSTG(NSTG), .W(W)) u_integ (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (started_q),
    .din  (integ_in),
    .dout (integ_out)
  );

  assign out_data = integ_out[W-1:TRUNC];
  assign out_vld  = started_q;
endmodule

// File: rtl/cic_interp32_chk.sv
module cic_interp32_chk #(
  parameter int OW = 16,
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic          out_vld,
  input logic [OW-1:0] out_data,
  input logic [CW-1:0] hold
);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_data == '0));

  p_vld_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> out_vld);

  p_vld_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_vld && in_vld) |=> out_vld);

  p_vld_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_vld && !in_vld) |=> !out_vld);

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(hold));
endmodule

bind cic_interp32 cic_interp32_chk #(
  .OW(IW + NSTG*RLOG2 - TRUNC),
  .CW(IW + NSTG)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .out_vld (out_vld),
  .out_data(out_data),
  .hold    (comb_hold)
);

// File: tb/test_cic_interp32.sv
module test_cic_interp32;
  localparam int CLK_PERIOD = 10;
  localparam int IW  = 8;
  localparam int NS  = 4;
  localparam int RL  = 5;
  localparam int RR  = 32;
  localparam int TR  = 4;
  localparam int OW  = IW + NS*RL - TR;
  localparam int GL  = (NS+1)*(RR-1) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] in_data = '0;
  logic          in_vld = 1'b0;
  logic [OW-1:0] out_data;
  logic          out_vld;

  int     n_run = 0;
  int     n_fail = 0;
  longint g  [0:GL-1];
  longint xs [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  cic_interp32 #(.IW(IW), .NSTG(NS), .RLOG2(RL), .TRUNC(TR)) i_cic_interp32 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_vld(in_vld),
    .out_data(out_data), .out_vld(out_vld)
  );

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic longint model(input int d, input int k);
    longint y = 0;
    for (int m = 0; m < k; m++) begin
      int idx = d - NS - RR*m;
      if (idx >= 0 && idx < GL) y += xs[m] * g[idx];
    end
    return y >>> TR;
  endfunction

  task automatic run_seq(input string tag, input int k, input int dc_d, input longint dc_val);
    rst_n   = 1'b0;
    in_vld  = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset data", longint'($signed(out_data)), 0);
    chk("R2 reset vld", longint'(out_vld), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      in_data = IW'($urandom);
      @(negedge clk);
      chk("R1 idle data", longint'($signed(out_data)), 0);
      chk("R2 idle vld", longint'(out_vld), 0);
    end
    for (int c = 0; c < k*RR + 200; c++) begin
      if (c > 0) begin
        chk("R2 vld", longint'(out_vld), 1);
        chk(tag, longint'($signed(out_data)), model(c-1, k));
        if (c-1 == dc_d) chk("R5 dc gain", longint'($signed(out_data)), dc_val);
      end
      if (c % RR == 0) begin
        in_vld  = 1'b1;
        in_data = (c/RR < k) ? IW'(xs[c/RR]) : '0;
      end else begin
        in_vld  = 1'b0;
        in_data = IW'($urandom);
      end
      @(negedge clk);
    end
    in_vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    longint t [0:GL-1];
    int len;
    for (int i = 0; i < GL; i++) g[i] = 0;
    g[0] = 1;
    len = 1;
    for (int s = 0; s <= NS; s++) begin
      for (int i = 0; i < GL; i++) begin
        t[i] = 0;
        for (int j = 0; j < RR; j++)
          if (i-j >= 0 && i-j < len) t[i] += g[i-j];
      end
      for (int i = 0; i < GL; i++) g[i] = t[i];
      len += RR - 1;
    end

    // Impulse: kernel shape and latency.
    for (int m = 0; m < 512; m++) xs[m] = 0;
    xs[0] = 1;
    run_seq("R4 impulse", 1, -1, 0);

    // Positive full-scale step.
    for (int m = 0; m < 12; m++) xs[m] = 127;
    run_seq("R7 step max", 12, NS + RR*8, longint'(127) <<< (NS*RL - TR));

    // Negative full-scale step.
    for (int m = 0; m < 12; m++) xs[m] = -128;
    run_seq("R7 step min", 12, NS + RR*8, -(longint'(128) <<< (NS*RL - TR)));

    // Alternating extremes.
    for (int m = 0; m < 16; m++) xs[m] = (m % 2 == 0) ? 127 : -128;
    run_seq("R7 alternate", 16, -1, 0);

    // Every input code in ascending order, random values between strobes.
    for (int m = 0; m < 256; m++) xs[m] = m - 128;
    run_seq("R3/R4/R6 sweep", 256, -1, 0);

    // Reset in the middle of activity.
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", longint'($signed(out_data)), 0);
    chk("R2 async clear", longint'(out_vld), 0);
    report();
  end
endmodule